// File: doc/BRIEF.md
# Reset Vector Sequencer

This block runs the start-up sequence of a 16-bit processor core. While the master reset input is held low it keeps the core aborted. It also forces the mode bits of the condition code register to a safe state and clears the extension register. Execution-side write-backs are discarded during this time.

After reset is released, it first latches the breakpoint request line. It then reads four words from consecutive memory locations over a request/acknowledge port. The first word holds three bank-extension nibbles, and the other three are the initial program counter, stack pointer and index register. When the last word arrives, it pulses a start signal to the fetch unit with the extended start address.

A reset that arrives in the middle of the sequence discards all progress. The next release starts again from the first word.

Top module: `rstvec_sequencer`

## Requirements
- R1: `abort_o` is 1 exactly while `mst_rst_n` is 0. A write-back (`wb_valid_i`) changes `ccr_o`/`k_o` only while `running_o` is 1; at any other time it has no effect.
- R2: Every clock edge with `mst_rst_n` low sets the interrupt mask field `ccr_o[7:5]` to 3'b111.
- R3: Every clock edge with `mst_rst_n` low sets the stop-disable bit `ccr_o[15]` to 1 and clears the saturation bit `ccr_o[4]`.
- R4: Every clock edge with `mst_rst_n` low clears `k_o` to zero.
- R5: The bits of `ccr_o` other than 15, 7:5 and 4 keep their value through reset.
- R6: The first edge after release moves the block to a sampling cycle with no memory request. The next edge latches `bkpt_i` into `sampled_bkpt_o`, which then holds until the next reset (reset clears it to 0).
- R7: The block issues exactly four reads, at word addresses VEC_BASE+0, +1, +2, +3 in that order. Each request stays asserted with a stable address until `mem_ack_i`, with no timeout.
- R8: Word 0 loads `zk_o` from bits [11:8], `sk_o` from bits [7:4] and `pk_o` from bits [3:0]. Words 1, 2 and 3 load `pc_o`, `sp_o` and `iz_o`.
- R9: One cycle after the fourth acknowledge, `start_fetch_o` is high for exactly one cycle. At that point `fetch_addr_o` equals {`pk_o`,`pc_o`}, and `running_o` rises the cycle after.
- R10: A reset at any point drops `mem_req_o` and `start_fetch_o` at the next edge. After the following release the sequence restarts at word 0.
- R11: While running, a write-back loads `wb_ccr_i` into `ccr_o` and `wb_k_i` into `k_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mst_rst_n | input | 1 | Master reset, active low, sampled on the clock |
| bkpt_i | input | 1 | Breakpoint request line |
| abort_o | output | 1 | Abort in-flight execution |
| mem_req_o | output | 1 | Vector read request |
| mem_addr_o | output | MADDR_W | Vector word address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | DATA_W | Read data |
| wb_valid_i | input | 1 | Execution write-back strobe |
| wb_ccr_i | input | DATA_W | Write-back value for condition codes |
| wb_k_i | input | DATA_W | Write-back value for extension register |
| ccr_o | output | DATA_W | Condition code register |
| k_o | output | DATA_W | Extension register |
| zk_o | output | EXT_W | Z bank extension |
| sk_o | output | EXT_W | Stack bank extension |
| pk_o | output | EXT_W | Program bank extension |
| pc_o | output | DATA_W | Initial program counter |
| sp_o | output | DATA_W | Initial stack pointer |
| iz_o | output | DATA_W | Initial index register |
| sampled_bkpt_o | output | 1 | Latched breakpoint request |
| start_fetch_o | output | 1 | One-cycle start pulse |
| fetch_addr_o | output | EXT_W+DATA_W | Extended start address |
| running_o | output | 1 | Sequence finished, core running |

## Verification
The bench builds the block with its defaults: 16-bit words, 4-bit extensions, a 16-bit vector address and a base of zero. These give a 20-bit start address, so a word-0 value with its top nibble set shows that the unused bits stay out of the three extension fields. The bench varies the acknowledge latency from zero to forty cycles, so back-to-back acknowledges and long stalls with a held request are both covered. It also asserts reset after the second acknowledge, which reaches the restart path.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_BKPT   = 3'd1,
        ST_VREQ   = 3'd2,
        ST_LAUNCH = 3'd3,
        ST_RUN    = 3'd4
    } seq_st_e;

    localparam int NUM_VEC  = 4;
    localparam int VIDX_W   = $clog2(NUM_VEC);

    // Vector slot order is behaviour: extensions, PC, SP, IZ
    localparam int SLOT_EXT = 0;
    localparam int SLOT_PC  = 1;
    localparam int SLOT_SP  = 2;
    localparam int SLOT_IZ  = 3;

    // Condition code bit positions
    localparam int CCR_STOPDIS = 15;
    localparam int CCR_IP_HI   = 7;
    localparam int CCR_IP_LO   = 5;
    localparam int CCR_SATMODE = 4;
    localparam logic [2:0] IP_RESET_VAL = 3'b111;

endpackage

// File: rtl/rvs_seq_fsm.sv
module rvs_seq_fsm
    import rvs_pkg::*;
#(
    parameter int MADDR_W  = 16,
    parameter int VEC_BASE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bkpt_i,
    input  logic               mem_ack_i,
    output seq_st_e            st_o,
    output logic [NUM_VEC-1:0] load_en_o,
    output logic               mem_req_o,
    output logic [MADDR_W-1:0] mem_addr_o,
    output logic               bkpt_o,
    output logic               start_o
);

    localparam logic [MADDR_W-1:0] BASE_A   = MADDR_W'(VEC_BASE);
    localparam logic [VIDX_W-1:0]  LAST_IDX = VIDX_W'(NUM_VEC - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [VIDX_W-1:0] idx;
        logic              bkpt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [NUM_VEC-1:0] load_d;

    always_comb begin
        fsm_d  = fsm_q;
        load_d = '0;
        unique case (fsm_q.st)
            ST_HOLD: begin
                fsm_d.st = ST_BKPT;
            end
            ST_BKPT: begin
                fsm_d.bkpt = bkpt_i;
                fsm_d.idx  = '0;
                fsm_d.st   = ST_VREQ;
            end
            ST_VREQ: begin
                if (mem_ack_i) begin
                    load_d[fsm_q.idx] = 1'b1;
                    if (fsm_q.idx == LAST_IDX) begin
                        fsm_d.st = ST_LAUNCH;
                    end else begin
                        fsm_d.idx = fsm_q.idx + 1'b1;
                    end
                end
            end
            ST_LAUNCH: begin
                fsm_d.st = ST_RUN;
            end
            ST_RUN: begin
                fsm_d.st = ST_RUN;
            end
            default: begin
                fsm_d.st = ST_HOLD;
            end
        endcase
        if (!rst_n) begin
            fsm_d.st   = ST_HOLD;
            fsm_d.idx  = '0;
            fsm_d.bkpt = 1'b0;
            load_d     = '0;
        end
    end

    always_ff @(posedge clk) begin
        fsm_q <= fsm_d;
    end

    assign st_o       = fsm_q.st;
    assign load_en_o  = load_d;
    assign mem_req_o  = (fsm_q.st == ST_VREQ);
    assign mem_addr_o = BASE_A + MADDR_W'(fsm_q.idx);
    assign bkpt_o     = fsm_q.bkpt;
    assign start_o    = (fsm_q.st == ST_LAUNCH);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R7

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R9

    AST_BKPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st != ST_BKPT) |=> $stable(bkpt_o)); // R6

    AST_NO_REQ_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_BKPT) |-> !mem_req_o); // R6

endmodule

// File: rtl/rvs_vec_regs.sv
module rvs_vec_regs
    import rvs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] load_en_i,
    input  logic [DATA_W-1:0]  rdata_i,
    output logic [EXT_W-1:0]   zk_o,
    output logic [EXT_W-1:0]   sk_o,
    output logic [EXT_W-1:0]   pk_o,
    output logic [DATA_W-1:0]  pc_o,
    output logic [DATA_W-1:0]  sp_o,
    output logic [DATA_W-1:0]  iz_o
);

    localparam int EXTS_W = 3 * EXT_W;

    typedef struct packed {
        logic [EXTS_W-1:0]               ext;
        logic [NUM_VEC-1:1][DATA_W-1:0]  word;
    } vregs_t;

    vregs_t vr_d, vr_q;

    always_comb begin
        vr_d = vr_q;
        if (load_en_i[SLOT_EXT]) begin
            vr_d.ext = rdata_i[EXTS_W-1:0];
        end
        for (int s = 1; s < NUM_VEC; s++) begin
            if (load_en_i[s]) begin
                vr_d.word[s] = rdata_i;
            end
        end
        if (!rst_n) begin
            vr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        vr_q <= vr_d;
    end

    assign pk_o = vr_q.ext[EXT_W-1:0];
    assign sk_o = vr_q.ext[2*EXT_W-1:EXT_W];
    assign zk_o = vr_q.ext[3*EXT_W-1:2*EXT_W];
    assign pc_o = vr_q.word[SLOT_PC];
    assign sp_o = vr_q.word[SLOT_SP];
    assign iz_o = vr_q.word[SLOT_IZ];

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_en_i)); // R7

endmodule

// File: rtl/rvs_ccr_ctrl.sv
module rvs_ccr_ctrl
    import rvs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_en_i,
    input  logic [DATA_W-1:0] wb_ccr_i,
    input  logic [DATA_W-1:0] wb_k_i,
    output logic [DATA_W-1:0] ccr_o,
    output logic [DATA_W-1:0] k_o
);

    typedef struct packed {
        logic [DATA_W-1:0] ccr;
        logic [DATA_W-1:0] k;
    } ccr_t;

    ccr_t cc_d, cc_q;

    // No register-wide reset: unnamed condition bits carry through reset
    always_comb begin
        cc_d = cc_q;
        if (wb_en_i) begin
            cc_d.ccr = wb_ccr_i;
            cc_d.k   = wb_k_i;
        end
        if (!rst_n) begin
            cc_d.ccr[CCR_IP_HI:CCR_IP_LO] = IP_RESET_VAL;
            cc_d.ccr[CCR_STOPDIS]         = 1'b1;
            cc_d.ccr[CCR_SATMODE]         = 1'b0;
            cc_d.k                        = '0;
        end
    end

    always_ff @(posedge clk) begin
        cc_q <= cc_d;
    end

    assign ccr_o = cc_q.ccr;
    assign k_o   = cc_q.k;

endmodule

// File: rtl/rstvec_sequencer.sv
module rstvec_sequencer
    import rvs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int EXT_W    = 4,
    parameter int MADDR_W  = 16,
    parameter int VEC_BASE = 0
) (
    input  logic                    clk,
    input  logic                    mst_rst_n,
    input  logic                    bkpt_i,
    output logic                    abort_o,
    output logic                    mem_req_o,
    output logic [MADDR_W-1:0]      mem_addr_o,
    input  logic                    mem_ack_i,
    input  logic [DATA_W-1:0]       mem_rdata_i,
    input  logic                    wb_valid_i,
    input  logic [DATA_W-1:0]       wb_ccr_i,
    input  logic [DATA_W-1:0]       wb_k_i,
    output logic [DATA_W-1:0]       ccr_o,
    output logic [DATA_W-1:0]       k_o,
    output logic [EXT_W-1:0]        zk_o,
    output logic [EXT_W-1:0]        sk_o,
    output logic [EXT_W-1:0]        pk_o,
    output logic [DATA_W-1:0]       pc_o,
    output logic [DATA_W-1:0]       sp_o,
    output logic [DATA_W-1:0]       iz_o,
    output logic                    sampled_bkpt_o,
    output logic                    start_fetch_o,
    output logic [EXT_W+DATA_W-1:0] fetch_addr_o,
    output logic                    running_o
);

    seq_st_e            st;
    logic [NUM_VEC-1:0] load_en;
    logic               wb_en;

    rvs_seq_fsm #(
        .MADDR_W  (MADDR_W),
        .VEC_BASE (VEC_BASE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (mst_rst_n),
        .bkpt_i     (bkpt_i),
        .mem_ack_i  (mem_ack_i),
        .st_o       (st),
        .load_en_o  (load_en),
        .mem_req_o  (mem_req_o),
        .mem_addr_o (mem_addr_o),
        .bkpt_o     (sampled_bkpt_o),
        .start_o    (start_fetch_o)
    );

    rvs_vec_regs #(
        .DATA_W (DATA_W),
        .EXT_W  (EXT_W)
    ) u_vregs (
        .clk       (clk),
        .rst_n     (mst_rst_n),
        .load_en_i (load_en),
        .rdata_i   (mem_rdata_i),
        .zk_o      (zk_o),
        .sk_o      (sk_o),
        .pk_o      (pk_o),
        .pc_o      (pc_o),
        .sp_o      (sp_o),
        .iz_o      (iz_o)
    );

    assign running_o = (st == ST_RUN);
    assign wb_en     = running_o && wb_valid_i && mst_rst_n;

    rvs_ccr_ctrl #(
        .DATA_W (DATA_W)
    ) u_ccr (
        .clk      (clk),
        .rst_n    (mst_rst_n),
        .wb_en_i  (wb_en),
        .wb_ccr_i (wb_ccr_i),
        .wb_k_i   (wb_k_i),
        .ccr_o    (ccr_o),
        .k_o      (k_o)
    );

    assign abort_o      = !mst_rst_n;
    assign fetch_addr_o = {pk_o, pc_o};

    AST_IP_FORCED: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (st == ST_BKPT) |-> (ccr_o[CCR_IP_HI:CCR_IP_LO] == IP_RESET_VAL)); // R2

    AST_MODE_BITS: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (st == ST_BKPT) |-> (ccr_o[CCR_STOPDIS] && !ccr_o[CCR_SATMODE])); // R3

    AST_K_CLEARED: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (st == ST_BKPT) |-> (k_o == '0)); // R4

    AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (!running_o && wb_valid_i) |=> ($stable(ccr_o) && $stable(k_o))); // R1

    AST_LAST_BEFORE_GO: assert property (@(posedge clk) disable iff (!mst_rst_n)
        start_fetch_o |-> $past(load_en[SLOT_IZ])); // R9

endmodule

// File: tb/rstvec_sequencer_tb_top.sv
module rstvec_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int EW = 4;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          mst_rst_n = 1'b0;
    logic          bkpt = 1'b0;
    logic          abort;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          wb_valid = 1'b0;
    logic [DW-1:0] wb_ccr = '0;
    logic [DW-1:0] wb_k = '0;
    logic [DW-1:0] ccr, kreg, pc, sp, iz;
    logic [EW-1:0] zk, sk, pk;
    logic          sbkpt, start_fetch, running;
    logic [EW+DW-1:0] fetch_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] vec_mem [4];
    int mem_lat = 0;
    int lat_cnt = 0;
    int rd_cnt = 0;
    logic [AW-1:0] addr_log [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    rstvec_sequencer dut_i (
        .clk            (clk),
        .mst_rst_n      (mst_rst_n),
        .bkpt_i         (bkpt),
        .abort_o        (abort),
        .mem_req_o      (mem_req),
        .mem_addr_o     (mem_addr),
        .mem_ack_i      (mem_ack),
        .mem_rdata_i    (mem_rdata),
        .wb_valid_i     (wb_valid),
        .wb_ccr_i       (wb_ccr),
        .wb_k_i         (wb_k),
        .ccr_o          (ccr),
        .k_o            (kreg),
        .zk_o           (zk),
        .sk_o           (sk),
        .pk_o           (pk),
        .pc_o           (pc),
        .sp_o           (sp),
        .iz_o           (iz),
        .sampled_bkpt_o (sbkpt),
        .start_fetch_o  (start_fetch),
        .fetch_addr_o   (fetch_addr),
        .running_o      (running)
    );

    // Memory responder, acts on the falling edge
    always @(negedge clk) begin
        if (mem_req) begin
            if (lat_cnt >= mem_lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= vec_mem[mem_addr[1:0]];
                addr_log[rd_cnt % 64] <= mem_addr;
                rd_cnt    <= rd_cnt + 1;
                lat_cnt   <= 0;
            end else begin
                mem_ack <= 1'b0;
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_reset_outputs(input string tag);
        check({tag, " R1 abort"}, 32'(abort), 32'd1);
        check({tag, " R2 ip"}, 32'(ccr[7:5]), 32'd7);
        check({tag, " R3 stopdis/sat"}, {30'd0, ccr[15], ccr[4]}, 32'b10);
        check({tag, " R4 k"}, 32'(kreg), 32'd0);
        check({tag, " R10 req/start"}, {30'd0, mem_req, start_fetch}, 32'd0);
    endtask

    task automatic run_boot(input int lat, input logic b, input bit full_ccr,
                            input logic [DW-1:0] exp_ccr);
        int base;
        int req_gap;
        int guard;
        base    = rd_cnt;
        req_gap = 0;
        guard   = 0;
        mem_lat = lat;
        mst_rst_n = 1'b1;
        bkpt = b;
        tick();
        check("R1 abort low", 32'(abort), 32'd0);
        check("R6 no req in sample cycle", 32'(mem_req), 32'd0);
        wb_valid = 1'b1;
        wb_ccr = ~exp_ccr;
        wb_k = 16'h5A5A;
        tick();
        wb_valid = 1'b0;
        bkpt = ~b;
        while (!start_fetch && guard < 2000) begin
            if (rd_cnt == base && !mem_req) req_gap++;
            tick();
            guard++;
        end
        check("R9 start seen", 32'(start_fetch), 32'd1);
        check("R7 no request gap", 32'(req_gap), 32'd0);
        check("R7 read count", 32'(rd_cnt - base), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R7 read order", 32'(addr_log[(base + i) % 64]), 32'(i));
        end
        check("R8 zk", 32'(zk), 32'(vec_mem[0][11:8]));
        check("R8 sk", 32'(sk), 32'(vec_mem[0][7:4]));
        check("R8 pk", 32'(pk), 32'(vec_mem[0][3:0]));
        check("R8 pc", 32'(pc), 32'(vec_mem[1]));
        check("R8 sp", 32'(sp), 32'(vec_mem[2]));
        check("R8 iz", 32'(iz), 32'(vec_mem[3]));
        check("R9 fetch addr", 32'(fetch_addr), {12'd0, vec_mem[0][3:0], vec_mem[1]});
        check("R6 bkpt held", 32'(sbkpt), 32'(b));
        check("R1 wb ignored k", 32'(kreg), 32'd0);
        if (full_ccr) check("R1 wb ignored ccr", 32'(ccr), 32'(exp_ccr));
        else check("R2 R3 ccr masked", 32'(ccr & 16'h80F0), 32'h80E0);
        tick();
        check("R9 pulse width", 32'(start_fetch), 32'd0);
        check("R9 running", 32'(running), 32'd1);
    endtask

    task automatic do_reset(input int cycles);
        mst_rst_n = 1'b0;
        for (int i = 0; i < cycles; i++) tick();
    endtask

    task automatic wb_write(input logic [DW-1:0] c, input logic [DW-1:0] k);
        wb_valid = 1'b1;
        wb_ccr = c;
        wb_k = k;
        tick();
        wb_valid = 1'b0;
        check("R11 ccr write", 32'(ccr), 32'(c));
        check("R11 k write", 32'(kreg), 32'(k));
    endtask

    task automatic test_reset_state();
        do_reset(3);
        check_reset_outputs("por");
        check("R9 running low", 32'(running), 32'd0);
    endtask

    task automatic test_boot_fast();
        vec_mem[0] = 16'h0A5C; vec_mem[1] = 16'h1234;
        vec_mem[2] = 16'h07FE; vec_mem[3] = 16'h4000;
        run_boot(0, 1'b1, 1'b0, 16'h0000);
    endtask

    task automatic test_ccr_retain();
        wb_write(16'h6B0F, 16'hBEEF);
        do_reset(2);
        check("R5 ccr keep", 32'(ccr), 32'hEBEF);
        check_reset_outputs("rst2");
        wb_valid = 1'b1; wb_ccr = 16'h0000; wb_k = 16'h1111;
        tick();
        wb_valid = 1'b0;
        check("R1 wb in reset ccr", 32'(ccr), 32'hEBEF);
        check("R1 wb in reset k", 32'(kreg), 32'd0);
        vec_mem[0] = 16'hF321; vec_mem[1] = 16'hBEE0;
        vec_mem[2] = 16'h0100; vec_mem[3] = 16'hFFFF;
        run_boot(2, 1'b0, 1'b1, 16'hEBEF);
        wb_write(16'h1234, 16'h0F0F);
        do_reset(1);
        check("R5 R3 ccr keep 2", 32'(ccr), 32'h92E4);
    endtask

    task automatic test_mid_reset();
        int base;
        int guard;
        base = rd_cnt;
        guard = 0;
        mem_lat = 3;
        mst_rst_n = 1'b1;
        while ((rd_cnt - base) < 2 && guard < 200) begin
            tick();
            guard++;
        end
        check("R10 two reads done", 32'(rd_cnt - base), 32'd2);
        mst_rst_n = 1'b0;
        tick();
        check_reset_outputs("mid");
        tick();
        vec_mem[0] = 16'h0789; vec_mem[1] = 16'h5555;
        vec_mem[2] = 16'hAAAA; vec_mem[3] = 16'h0001;
        run_boot(1, 1'b1, 1'b1, 16'h92E4);
    endtask

    task automatic test_slow_memory();
        do_reset(2);
        vec_mem[0] = 16'h0123; vec_mem[1] = 16'h0F00;
        vec_mem[2] = 16'h3333; vec_mem[3] = 16'h7777;
        run_boot(40, 1'b0, 1'b1, 16'h92E4);
    endtask

    initial begin
        vec_mem[0] = '0; vec_mem[1] = '0; vec_mem[2] = '0; vec_mem[3] = '0;
        test_reset_state();
        test_boot_fast();
        test_ccr_retain();
        test_mid_reset();
        test_slow_memory();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule